// File: doc/BRIEF.md
# Strobe-Sequenced Expansion Bus Master

This block runs one transfer at a time on an expansion bus that has no shared clock. Each step of a transfer is set off by a strobe, and master and slave take turns driving the strobes. The upper 24 lines carry the address first and the data afterwards. The lower address bits and a three-bit space code have lines of their own.

A local client hands over a request on a valid/ready handshake. The request holds:
- the word address,
- the space code,
- a read/write flag,
- byte enables,
- write data.

The sequencer then steps through the bus cycle:
1. It presents the address.
2. It asserts the full-cycle strobe.
3. It lets go of the shared lines.
4. It opens the data phase.
5. It asserts the byte strobes.
6. It waits for the slave's acknowledge.
7. It closes the cycle.

Every strobe level is held for at least one master clock. Both slave inputs pass through two-flop synchronisers.

When the transfer ends, the client gets a one-clock done pulse with the read data and an error flag. The error flag is set when the cycle was cut short, either by a bus-error input or by an acknowledge that never came.

Top module: `strobe_bus_master`

## Requirements
- R1: `req_ready` is high only while no cycle is in progress. A request is taken on a clock where `req_valid` and `req_ready` are both high. Each taken request gives exactly one `rsp_done` pulse, one clock long.
- R2: In the address phase the master drives `bus_ad_o[31:8]` with address bits 31..8, with `bus_ad_oe`=1. It also drives `bus_lo_addr` with address bits 7..2, `bus_space` with the space code, and `bus_read`=1 for a read. `bus_fcs_n` falls only after that, at least one clock later. It waits until both synchronised slave inputs (acknowledge and bus error) are deasserted.
- R3: After `bus_fcs_n` has been low for one clock, `bus_ad_oe` drops. `bus_doe` rises one clock later, while `bus_ad_oe` is still 0.
- R4: `bus_ds_n` leaves 4'hF only while `bus_doe`=1 and `bus_fcs_n`=0. Its value is then the inverted byte enables (bit n low means byte lane n). A request with all enables zero asserts all four strobes.
- R5: On a read, `bus_ad_oe` stays 0 through the data phase. The strobes assert the clock after `bus_doe` rises. The word on `bus_ad_i` at the clock the acknowledge is seen comes back on `rsp_rdata`.
- R6: On a write, `bus_ad_o` carries the write data with `bus_ad_oe`=1 for one full clock before the strobes assert. That data is held until the cycle ends.
- R7: The synchronised acknowledge (`bus_dtack_n`, low active) is acted on only while the strobes are asserted, so an acknowledge raised early still gets a strobed data phase. Once the acknowledge is seen, the next clock does all of the following together: negates `bus_fcs_n`, `bus_doe` and `bus_ds_n`; releases `bus_ad_oe`; pulses `rsp_done` with `rsp_err`=0. On a write, `rsp_rdata` is 0.
- R8: If no acknowledge is seen, the strobes stay asserted for exactly `TMO_CYCLES` clocks. The cycle then ends with `rsp_err`=1 and `rsp_rdata`=0.
- R9: A synchronised bus error (`bus_berr_n` low) seen at any point between `bus_fcs_n` falling and the acknowledge ends the cycle at once, with `rsp_err`=1 and `rsp_rdata`=0. It takes priority over an acknowledge in the same clock.
- R10: During and right after reset, the outputs are: `req_ready`=1, `bus_fcs_n`=1, `bus_doe`=0, `bus_ds_n`=4'hF, `bus_ad_oe`=0, `rsp_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | request can be taken |
| req_addr | input | 30 | word address, bits 31..2 |
| req_space | input | 3 | memory space code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | byte enables, bit n = lane n |
| req_wdata | input | 32 | write data |
| rsp_done | output | 1 | one-clock end-of-transfer pulse |
| rsp_rdata | output | 32 | read data, valid with rsp_done |
| rsp_err | output | 1 | transfer aborted, valid with rsp_done |
| bus_ad_o | output | 32 | shared address/data lines, out |
| bus_ad_oe | output | 1 | drive enable for bus_ad_o |
| bus_ad_i | input | 32 | shared address/data lines, in |
| bus_lo_addr | output | 6 | non-multiplexed address bits 7..2 |
| bus_space | output | 3 | space code lines |
| bus_read | output | 1 | transfer direction, 1 = read |
| bus_fcs_n | output | 1 | full-cycle strobe, active low |
| bus_doe | output | 1 | data-phase enable |
| bus_ds_n | output | 4 | byte data strobes, active low |
| bus_dtack_n | input | 1 | slave acknowledge, active low, asynchronous |
| bus_berr_n | input | 1 | bus error, active low, asynchronous |

## Verification
Some rules can be checked at every clock, and the assertions cover those:
- the order of the strobes;
- that strobes appear only inside an open data phase;
- the release of the shared lines before `bus_doe`, and on reads;
- that write data is held before the strobes;
- the single-clock done pulse;
- that `bus_fcs_n` does not rise without strobes unless the cycle is an error;
- that the handshake is idle-only.

Other behaviour needs a slave model, and only the bench scenarios can show it:
- the read data path;
- the strobe values that depend on the byte enables;
- the exact timeout length;
- the bus-error abort;
- an acknowledge that arrives early or stays stuck low.

// File: rtl/strobe_bus_master.sv
module strobe_bus_master #(
  parameter int TMO_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:2] req_addr,
  input  logic [2:0]  req_space,
  input  logic        req_write,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rsp_done,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic [31:0] bus_ad_o,
  output logic        bus_ad_oe,
  input  logic [31:0] bus_ad_i,
  output logic [5:0]  bus_lo_addr,
  output logic [2:0]  bus_space,
  output logic        bus_read,
  output logic        bus_fcs_n,
  output logic        bus_doe,
  output logic [3:0]  bus_ds_n,
  input  logic        bus_dtack_n,
  input  logic        bus_berr_n
);

  localparam int CW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_FCS, S_TURN, S_DOE, S_WDAT, S_STRB, S_END
  } state_t;

  state_t       st;
  logic [31:2]  a_q;
  logic [2:0]   sp_q;
  logic         wr_q;
  logic [3:0]   be_q;
  logic [31:0]  wd_q;
  logic [CW-1:0] cnt;
  logic [1:0]   dt_sync, be_sync;

  wire ack_seen  = !dt_sync[1];
  wire berr_seen = !be_sync[1];
  wire live      = st inside {S_FCS, S_TURN, S_DOE, S_WDAT, S_STRB};
  wire addr_ph   = st inside {S_ADDR, S_FCS};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_sync <= 2'b11;
      be_sync <= 2'b11;
    end else begin
      dt_sync <= {dt_sync[0], bus_dtack_n};
      be_sync <= {be_sync[0], bus_berr_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      a_q       <= '0;
      sp_q      <= '0;
      wr_q      <= 1'b0;
      be_q      <= 4'hF;
      wd_q      <= '0;
      cnt       <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (live && berr_seen) begin
      st        <= S_END;
      rsp_err   <= 1'b1;
      rsp_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a_q  <= req_addr;
          sp_q <= req_space;
          wr_q <= req_write;
          be_q <= (req_be == 4'h0) ? 4'hF : req_be;
          wd_q <= req_wdata;
          st   <= S_ADDR;
        end
        S_ADDR: if (!ack_seen && !berr_seen) st <= S_FCS;
        S_FCS:  st <= S_TURN;
        S_TURN: st <= S_DOE;
        S_DOE: begin
          cnt <= '0;
          st  <= wr_q ? S_WDAT : S_STRB;
        end
        S_WDAT: st <= S_STRB;
        S_STRB: begin
          if (ack_seen) begin
            rsp_rdata <= wr_q ? 32'h0 : bus_ad_i;
            rsp_err   <= 1'b0;
            st        <= S_END;
          end else if (cnt == CW'(TMO_CYCLES - 1)) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b1;
            st        <= S_END;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign rsp_done    = (st == S_END);
  assign bus_ad_oe   = addr_ph || (wr_q && st inside {S_WDAT, S_STRB});
  assign bus_ad_o    = addr_ph ? {a_q[31:8], 8'h00} : wd_q;
  assign bus_lo_addr = a_q[7:2];
  assign bus_space   = sp_q;
  assign bus_read    = !wr_q;
  assign bus_fcs_n   = !live;
  assign bus_doe     = st inside {S_DOE, S_WDAT, S_STRB};
  assign bus_ds_n    = (st == S_STRB) ? ~be_q : 4'hF;

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_fcs_n && !bus_doe && bus_ds_n == 4'hF); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R1
  AST_ADDR_BEFORE_FCS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_fcs_n) |-> $past(bus_ad_oe) && bus_ad_oe); // R2
  AST_AD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_doe) |-> !bus_ad_oe && !$past(bus_fcs_n)); // R3
  AST_DS_IN_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ds_n != 4'hF |-> bus_doe && !bus_fcs_n); // R4
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe && bus_read |-> !bus_ad_oe); // R5
  AST_WDATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_read && bus_ds_n != 4'hF && $past(bus_ds_n) == 4'hF)
      |-> $past(bus_ad_oe) && $stable(bus_ad_o)); // R6
  AST_END_NEEDS_DS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_fcs_n) && !rsp_err) |-> $past(bus_ds_n) != 4'hF); // R7
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> bus_fcs_n && !bus_doe && !bus_ad_oe && bus_ds_n == 4'hF); // R7

endmodule

// File: tb/test_strobe_bus_master.sv
module test_strobe_bus_master;
  localparam int TMO = 24;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:2] req_addr = '0;
  logic [2:0]  req_space = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0, bus_ad_i = 32'hDEAD_BEEF;
  logic        bus_dtack_n = 1'b1, bus_berr_n = 1'b1;
  logic        req_ready, rsp_done, rsp_err, bus_ad_oe, bus_read, bus_fcs_n, bus_doe;
  logic [31:0] rsp_rdata, bus_ad_o;
  logic [5:0]  bus_lo_addr;
  logic [2:0]  bus_space;
  logic [3:0]  bus_ds_n;

  strobe_bus_master #(.TMO_CYCLES(TMO)) i_strobe_bus_master (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, wcnt = 0, ack_delay = 0, ds_cycles = 0;
  bit no_ack = 0, early_ack = 0, berr_mode = 0, stuck_ack = 0;
  logic [31:0] exp_addr, exp_wdata, slave_rdata;
  logic [2:0]  exp_space;
  logic        exp_wr;
  logic [3:0]  exp_be;

  function automatic logic [3:0] be_eff(input logic [3:0] b);
    return (b == 4'h0) ? 4'hF : b;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (stuck_ack) bus_dtack_n <= 1'b0;
    else if (bus_fcs_n) begin bus_dtack_n <= 1'b1; wcnt <= 0; end
    else if (early_ack) begin bus_dtack_n <= 1'b0; bus_ad_i <= slave_rdata; end
    else if (bus_ds_n != 4'hF && !no_ack) begin
      if (wcnt >= ack_delay) begin bus_dtack_n <= 1'b0; bus_ad_i <= slave_rdata; end
      else wcnt <= wcnt + 1;
    end
    if (berr_mode && !bus_fcs_n) bus_berr_n <= 1'b0;
    else if (bus_fcs_n) bus_berr_n <= 1'b1;
  end

  logic p_fcs_n = 1'b1, p_ad_oe = 1'b0, p_doe = 1'b0;
  logic [31:0] p_ad_o = '0;
  logic [3:0]  p_ds_n = 4'hF;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_fcs_n && !bus_fcs_n) begin
        chk(p_ad_oe && p_ad_o[31:8] == exp_addr[31:8], "R2 address before strobe", p_ad_o, exp_addr);
        chk(bus_lo_addr == exp_addr[7:2] && bus_space == exp_space && bus_read == !exp_wr,
            "R2 low address/space/dir", {bus_lo_addr, bus_space, bus_read}, {exp_addr[7:2], exp_space, !exp_wr});
      end
      if (!p_doe && bus_doe)
        chk(!bus_ad_oe && !bus_fcs_n && !p_fcs_n, "R3 release before doe", bus_ad_oe, 0);
      if (bus_ds_n != 4'hF) begin
        ds_cycles++;
        if (!(bus_doe && !bus_fcs_n)) chk(0, "R4 strobe outside data phase", bus_doe, 1);
      end
      if (p_ds_n == 4'hF && bus_ds_n != 4'hF) begin
        chk(bus_ds_n == ~be_eff(exp_be), "R4 strobe pattern", bus_ds_n, ~be_eff(exp_be));
        if (exp_wr) chk(p_ad_oe && p_ad_o == exp_wdata && bus_ad_o == exp_wdata, "R6 data before strobes", p_ad_o, exp_wdata);
        else        chk(!bus_ad_oe && !p_ad_oe && p_doe, "R5 read strobes after doe", bus_ad_oe, 0);
      end
    end
    p_fcs_n <= bus_fcs_n; p_ad_oe <= bus_ad_oe; p_ad_o <= bus_ad_o;
    p_ds_n <= bus_ds_n; p_doe <= bus_doe;
  end

  task automatic start_txn(input bit wr, input logic [31:0] addr, input logic [2:0] sp,
                           input logic [3:0] be, input logic [31:0] wd, input logic [31:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_wr = wr; exp_addr = {addr[31:2], 2'b00}; exp_space = sp; exp_be = be;
    exp_wdata = wd; slave_rdata = rd; ds_cycles = 0;
    req_valid = 1'b1; req_write = wr; req_addr = addr[31:2]; req_space = sp;
    req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 ready low while busy", req_ready, 0);
  endtask

  task automatic wait_done(input bit exp_err, input string rq);
    int n = 0;
    logic [31:0] er;
    while (!rsp_done && n < 2000) begin @(negedge clk); n++; end
    er = (exp_err || exp_wr) ? 32'h0 : slave_rdata;
    chk(rsp_done, {rq, " done seen"}, rsp_done, 1);
    chk(rsp_err == exp_err && rsp_rdata == er, {rq, " response"}, {rsp_rdata[30:0], rsp_err}, {er[30:0], exp_err});
    chk(bus_fcs_n && !bus_doe && !bus_ad_oe && bus_ds_n == 4'hF, "R7 bus released at done", bus_fcs_n, 1);
    @(negedge clk);
    chk(!rsp_done, "R1 single done pulse", rsp_done, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(req_ready && bus_fcs_n && !bus_doe && bus_ds_n == 4'hF && !bus_ad_oe && !rsp_done,
        "R10 reset state", {req_ready, bus_fcs_n, bus_doe, bus_ad_oe, rsp_done}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && bus_fcs_n && !rsp_done, "R10 after reset", {req_ready, bus_fcs_n}, 2'b11);

    start_txn(0, 32'h1234_5678, 3'd1, 4'h0, 32'h0, 32'hCAFE_F00D);
    wait_done(0, "R5 read all lanes");
    start_txn(1, 32'hA5A5_00FC, 3'd2, 4'h3, 32'h1122_3344, 32'h0);
    wait_done(0, "R6 write low half");

    for (int i = 0; i < 40; i++) begin
      ack_delay = $urandom_range(0, 5);
      start_txn($urandom_range(0, 1), $urandom, 3'($urandom_range(0, 7)),
                4'($urandom_range(0, 15)), $urandom, $urandom);
      wait_done(0, "R7 random cycle");
    end
    ack_delay = 0;

    early_ack = 1;
    start_txn(0, 32'h0000_0104, 3'd5, 4'h8, 32'h0, 32'h7777_0001);
    wait_done(0, "R7 early ack");
    chk(ds_cycles >= 1, "R7 strobes before early ack used", ds_cycles, 1);
    early_ack = 0;

    no_ack = 1;
    start_txn(0, 32'h0F00_0010, 3'd1, 4'hF, 32'h0, 32'h5555_AAAA);
    wait_done(1, "R8 timeout read");
    chk(ds_cycles == TMO, "R8 strobe length", ds_cycles, TMO);
    start_txn(1, 32'h0F00_0020, 3'd1, 4'h1, 32'h9999_0000, 32'h0);
    wait_done(1, "R8 timeout write");
    chk(ds_cycles == TMO, "R8 strobe length write", ds_cycles, TMO);
    no_ack = 0;

    berr_mode = 1;
    start_txn(0, 32'h4000_0000, 3'd1, 4'hF, 32'h0, 32'h1357_9BDF);
    wait_done(1, "R9 bus error read");
    start_txn(1, 32'h4000_0004, 3'd1, 4'hC, 32'h2468_ACE0, 32'h0);
    wait_done(1, "R9 bus error write");
    berr_mode = 0;

    stuck_ack = 1;
    start_txn(1, 32'h8000_0040, 3'd3, 4'h6, 32'hBEEF_0001, 32'h0);
    begin
      bit held = 1;
      repeat (10) begin @(negedge clk); if (!bus_fcs_n) held = 0; end
      chk(held, "R2 strobe waits for ack release", bus_fcs_n, 1);
    end
    stuck_ack = 0;
    wait_done(0, "R2 after ack release");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule